// File: doc/BRIEF.md
# Shutdown and Wake-up Pin Controller

This block drives two power-control output pins: an active-low shutdown pin and a wake-up pin. It also watches a wake-up input and an alarm pulse from a real-time clock. Software writes a mode register to set up the block. The mode register holds the level that each output pin should take, which transition on the wake-up input counts as a wake-up, and whether an alarm may cause a wake-up, a shutdown, or both. A pin level written into the mode register does nothing by itself. It reaches the pin only when software writes the matching bit of the command register.

The wake-up input is synchronized before it is examined. A qualifying edge, or an enabled alarm, produces a one-cycle pulse on `wake_evt_o`. An enabled alarm can also pull the shutdown pin low at once, with no command write. Software reads back the mode register and the current levels of both pins through the same register port.

Top module: `pwr_pin_ctrl`

## Requirements
- R1: After an asynchronous reset (`rst_n` low), `shdn_o` is 1, `wake_o` is 0, `wake_evt_o` is 0 and the mode register reads 0.
- R2: Mode bits [5:4] choose which wake-up input edge counts: 00 none, 01 rising, 10 falling, 11 either. Say `wake_i` changes before clock edge k. A matching change raises `wake_evt_o` after edge k+2, and it stays high for one cycle.
- R3: When mode bit 6 is 1, `alarm_i` sampled high at an edge raises `wake_evt_o` for the following cycle. When bit 6 is 0, the alarm gives no event.
- R4: When mode bit 7 is 1, `alarm_i` sampled high drives `shdn_o` to 0 after that same edge. This wins over a shutdown command in the same cycle. When bit 7 is 0, the alarm leaves `shdn_o` unchanged.
- R5: Writing command bit 0 (address 1) applies mode bits [1:0] to `shdn_o` after the write edge. The codes are 00 keep, 01 low, 10 high, 11 toggle.
- R6: Writing command bit 1 (address 1) applies mode bits [3:2] to `wake_o`, using the same codes as R5. Each command bit affects only its own pin.
- R7: Address 0 reads back the mode register. Address 2 reads the pin levels: bit 0 is `shdn_o` and bit 1 is `wake_o`.
- R8: Command bits clear themselves. Address 1 always reads 0, and one write applies its selection exactly once.
- R9: A write to the mode register does not change either output pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, combinational |
| wake_i | input | 1 | Asynchronous wake-up input pin |
| alarm_i | input | 1 | Real-time-clock alarm pulse |
| shdn_o | output | 1 | Shutdown pin, active low |
| wake_o | output | 1 | Wake-up pin |
| wake_evt_o | output | 1 | One-cycle wake-up event |

## Verification
A command write or an enabled alarm changes the pins right after the edge that samples it. The bench drives each stimulus at a falling edge and checks the pins at the next falling edge. An alarm event appears one cycle after the alarm is sampled. An edge on the wake-up input appears only after edge k+2, because of the two synchronizer flops and the edge register. For each edge code the bench therefore checks that `wake_evt_o` is still low one falling edge before that point, high at that point, and low again one cycle later. Read data is combinational, so it is sampled a short delay after the read address is set.

// File: rtl/pwr_pin_pkg.sv
package pwr_pin_pkg;
   localparam int ADR_MODE = 0;
   localparam int ADR_CMD  = 1;
   localparam int ADR_PINS = 2;

   typedef enum logic [1:0] {
      PIN_KEEP   = 2'b00,
      PIN_LOW    = 2'b01,
      PIN_HIGH   = 2'b10,
      PIN_TOGGLE = 2'b11
   } pin_sel_e;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   typedef struct packed {
      logic      alarm_shdn_en;
      logic      alarm_wake_en;
      edge_sel_e edge_sel;
      pin_sel_e  wake_sel;
      pin_sel_e  shdn_sel;
   } mode_t;
endpackage

// File: rtl/pwr_edge_det.sv
module pwr_edge_det #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o,
   output logic fall_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("pwr_edge_det: SYNC_STAGES must be at least 2");
   end

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sync_q[i] <= 1'b0;
         else if (i == 0)
            sync_q[i] <= async_i;
         else
            sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign rise_o =  sync_q[SYNC_STAGES-1] & ~prev_q;
   assign fall_o = ~sync_q[SYNC_STAGES-1] &  prev_q;
endmodule

// File: rtl/pwr_pin_drv.sv
module pwr_pin_drv
   import pwr_pin_pkg::*;
#(
   parameter logic RST_LVL = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     apply_i,
   input  pin_sel_e sel_i,
   input  logic     force_lo_i,
   output logic     pin_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pin_o <= RST_LVL;
      else if (force_lo_i)
         pin_o <= 1'b0;
      else if (apply_i) begin
         case (sel_i)
            PIN_LOW:    pin_o <= 1'b0;
            PIN_HIGH:   pin_o <= 1'b1;
            PIN_TOGGLE: pin_o <= ~pin_o;
            default:    pin_o <= pin_o;
         endcase
      end
   end
endmodule

// File: rtl/pwr_pin_ctrl.sv
module pwr_pin_ctrl
   import pwr_pin_pkg::*;
#(
   parameter int   ADDR_W      = 2,
   parameter int   DATA_W      = 8,
   parameter int   SYNC_STAGES = 2,
   parameter logic SHDN_RST    = 1'b1,
   parameter logic WAKE_RST    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wake_i,
   input  logic              alarm_i,
   output logic              shdn_o,
   output logic              wake_o,
   output logic              wake_evt_o
);
   localparam int MODE_W = $bits(mode_t);

   if (DATA_W < MODE_W) begin : g_bad_width
      $error("pwr_pin_ctrl: DATA_W must hold the mode register");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("pwr_pin_ctrl: ADDR_W must be at least 2");
   end

   mode_t mode_q;
   logic  wr_mode, wr_cmd;
   logic  shdn_apply, wake_apply, alarm_shdn;
   logic  in_rise, in_fall, edge_hit, evt_q;

   assign wr_mode = wr_en && (wr_addr == ADDR_W'(ADR_MODE));
   assign wr_cmd  = wr_en && (wr_addr == ADDR_W'(ADR_CMD));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (wr_mode) mode_q <= mode_t'(wr_data[MODE_W-1:0]);
   end

   assign shdn_apply = wr_cmd & wr_data[0];
   assign wake_apply = wr_cmd & wr_data[1];
   assign alarm_shdn = alarm_i & mode_q.alarm_shdn_en;

   pwr_pin_drv #(.RST_LVL(SHDN_RST)) u_shdn (
      .clk(clk), .rst_n(rst_n), .apply_i(shdn_apply), .sel_i(mode_q.shdn_sel),
      .force_lo_i(alarm_shdn), .pin_o(shdn_o));

   pwr_pin_drv #(.RST_LVL(WAKE_RST)) u_wake (
      .clk(clk), .rst_n(rst_n), .apply_i(wake_apply), .sel_i(mode_q.wake_sel),
      .force_lo_i(1'b0), .pin_o(wake_o));

   pwr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .async_i(wake_i), .rise_o(in_rise), .fall_o(in_fall));

   always_comb begin
      case (mode_q.edge_sel)
         EDGE_RISE: edge_hit = in_rise;
         EDGE_FALL: edge_hit = in_fall;
         EDGE_BOTH: edge_hit = in_rise | in_fall;
         default:   edge_hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= 1'b0;
      else        evt_q <= edge_hit | (alarm_i & mode_q.alarm_wake_en);
   end
   assign wake_evt_o = evt_q;

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(ADR_MODE))
         rd_data[MODE_W-1:0] = mode_q;
      else if (rd_addr == ADDR_W'(ADR_PINS))
         rd_data[1:0] = {wake_o, shdn_o};
   end
endmodule

// File: rtl/pwr_pin_ctrl_chk.sv
module pwr_pin_ctrl_chk #(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              alarm_i,
   input logic              shdn_o,
   input logic              wake_o,
   input logic              wake_evt_o,
   input logic [7:0]        mode_q
);
   logic cmd_s, cmd_w;
   assign cmd_s = wr_en && (wr_addr == ADDR_W'(1)) && wr_data[0];
   assign cmd_w = wr_en && (wr_addr == ADDR_W'(1)) && wr_data[1];

   p_shdn_low_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_s && mode_q[1:0] == 2'b01) |=> !shdn_o);

   p_shdn_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_s && !(alarm_i && mode_q[7])) |=> $stable(shdn_o));

   p_wake_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_w |=> $stable(wake_o));

   p_wake_high_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && mode_q[3:2] == 2'b10) |=> wake_o);

   p_alarm_shdn_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_i && mode_q[7]) |=> !shdn_o);

   p_alarm_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_i && mode_q[6]) |=> wake_evt_o);

   p_cmd_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(1)) |-> (rd_data == '0));
endmodule

bind pwr_pin_ctrl pwr_pin_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_pwr_pin_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_pin_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       wake_i = 1'b0;
   logic       alarm_i = 1'b0;
   logic       shdn_o, wake_o, wake_evt_o;

   int n_chk = 0;
   int n_fail = 0;
   logic exp_shdn, exp_wake;

   always #5 clk = ~clk;

   pwr_pin_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .wake_i(wake_i), .alarm_i(alarm_i),
      .shdn_o(shdn_o), .wake_o(wake_o), .wake_evt_o(wake_evt_o));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      rd_addr = a; #1; d = rd_data;
   endtask

   function automatic logic nxt(input logic cur, input logic [1:0] sel);
      case (sel)
         2'b01: return 1'b0;
         2'b10: return 1'b1;
         2'b11: return ~cur;
         default: return cur;
      endcase
   endfunction

   initial begin
      #1_000_000;
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rd(2'd0, d);
      chk("R1 shdn", {7'b0, shdn_o}, 8'd1);
      chk("R1 wake", {7'b0, wake_o}, 8'd0);
      chk("R1 evt", {7'b0, wake_evt_o}, 8'd0);
      chk("R1 mode", d, 8'd0);
      rst_n = 1'b1;
      exp_shdn = 1'b1; exp_wake = 1'b0;

      for (int st = 0; st < 2; st++) begin
         for (int sel = 0; sel < 4; sel++) begin
            logic [1:0] fix;
            fix = (st == 1) ? 2'b10 : 2'b01;
            wr(2'd0, {4'b0, fix, fix});
            wr(2'd1, 8'h03);
            exp_shdn = st[0]; exp_wake = st[0];
            wr(2'd0, {4'b0, sel[1:0], sel[1:0]});
            chk("R9 shdn after mode write", {7'b0, shdn_o}, {7'b0, exp_shdn});
            chk("R9 wake after mode write", {7'b0, wake_o}, {7'b0, exp_wake});
            rd(2'd0, d);
            chk("R7 mode readback", d, {4'b0, sel[1:0], sel[1:0]});
            wr(2'd1, 8'h01);
            exp_shdn = nxt(exp_shdn, sel[1:0]);
            chk("R5 shdn sel", {7'b0, shdn_o}, {7'b0, exp_shdn});
            chk("R6 wake untouched by shdn cmd", {7'b0, wake_o}, {7'b0, exp_wake});
            wr(2'd1, 8'h02);
            exp_wake = nxt(exp_wake, sel[1:0]);
            chk("R6 wake sel", {7'b0, wake_o}, {7'b0, exp_wake});
            chk("R5 shdn untouched by wake cmd", {7'b0, shdn_o}, {7'b0, exp_shdn});
            rd(2'd2, d);
            chk("R7 pin status", d, {6'b0, exp_wake, exp_shdn});
            rd(2'd1, d);
            chk("R8 cmd reads zero", d, 8'd0);
            repeat (3) @(negedge clk);
            chk("R8 no repeat shdn", {7'b0, shdn_o}, {7'b0, exp_shdn});
            chk("R8 no repeat wake", {7'b0, wake_o}, {7'b0, exp_wake});
         end
      end

      for (int es = 0; es < 4; es++) begin
         for (int dir = 0; dir < 2; dir++) begin
            logic hit;
            wr(2'd0, {2'b00, es[1:0], 4'b0});
            hit = (dir == 0) ? (es == 1 || es == 3) : (es == 2 || es == 3);
            @(negedge clk);
            wake_i = (dir == 0);
            @(negedge clk); @(negedge clk);
            chk("R2 evt not early", {7'b0, wake_evt_o}, 8'd0);
            @(negedge clk);
            chk("R2 evt on edge", {7'b0, wake_evt_o}, {7'b0, hit});
            @(negedge clk);
            chk("R2 evt one cycle", {7'b0, wake_evt_o}, 8'd0);
         end
      end

      wr(2'd0, 8'h0A);
      wr(2'd1, 8'h03);
      @(negedge clk); alarm_i = 1'b1;
      @(negedge clk); alarm_i = 1'b0;
      chk("R3 alarm no wake when disabled", {7'b0, wake_evt_o}, 8'd0);
      chk("R4 alarm no shdn when disabled", {7'b0, shdn_o}, 8'd1);
      wr(2'd0, 8'h4A);
      @(negedge clk); alarm_i = 1'b1;
      @(negedge clk); alarm_i = 1'b0;
      chk("R3 alarm wake", {7'b0, wake_evt_o}, 8'd1);
      chk("R4 shdn kept without enable", {7'b0, shdn_o}, 8'd1);
      @(negedge clk);
      chk("R3 alarm event one cycle", {7'b0, wake_evt_o}, 8'd0);
      wr(2'd0, 8'h8A);
      @(negedge clk);
      alarm_i = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h01;
      @(negedge clk);
      alarm_i = 1'b0; wr_en = 1'b0;
      chk("R4 alarm shdn wins over cmd", {7'b0, shdn_o}, 8'd0);
      chk("R3 no wake event with bit6 clear", {7'b0, wake_evt_o}, 8'd0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule